// File: doc/BRIEF.md
# DMA Channel Register Block with Address Sequencer

This block holds the programming state of one DMA channel on a 32-bit register bus. Software loads a current pointer, a limit, a reload pair (start and stop), an initial-buffer pointer and a size word. It then drives the channel through a control register whose written bits act as commands: each written 1 sets or clears one flag, and each written 0 leaves the flags alone. Reading the control register returns the flags.

While the channel is enabled, the block presents a request to the peripheral and shows the current pointer on a memory-address output. Each acknowledge from the peripheral moves the pointer on by one 32-bit word. When the pointer lands on the limit, the channel marks itself complete and raises an interrupt. If single-update mode is off, it also reloads start and stop into the current pointer and the limit and keeps running, which gives chained buffers. If single-update mode is on, it stops. The interrupt stays up until software writes the clear-complete command.

Top module: `dmach_regs`

## Requirements
- R1: Only whole-word accesses are accepted: all four byte enables set and address bits [1:0] equal to zero. Any other access changes no state, and a read of that kind returns zero.
- R2: Writes to the address registers take the full 32-bit word, and reads return the value held. The offsets are: current 0x4000, limit 0x4004, start 0x4008, stop 0x400C, initial buffer 0x4200, size 0x4204.
- R3: The control register is at offset 0x0. Writing bit 2 sets the device-to-memory flag, and writing bit 0 sets the enable flag. A read returns enable in bit 0, single-update in bit 1, direction in bit 2 and complete in bit 3. All other bits read as zero. `xfer_dir` shows the direction flag.
- R4: Writing bit 1 of the control register sets the single-update flag. Writing bit 3 clears the complete flag.
- R5: Writing bit 4 of the control register clears enable, single-update, direction and complete together. This takes priority over any set command in the same write and over a completion in the same cycle.
- R6: A control write with a bit at 0 leaves the matching flag unchanged, so writing all zeros changes nothing.
- R7: Reads of unmapped offsets return zero, and writes to them change nothing.
- R8: While enabled, each cycle with `dev_ack` high adds 4 to the current pointer. `mem_addr` always shows the current pointer, and `dev_req` shows the enable flag. An acknowledge while disabled has no effect.
- R9: An acknowledge that brings the pointer to equal the limit sets complete. With single-update clear, the same acknowledge loads start into the current pointer and stop into the limit, and enable stays set.
- R10: With single-update set, the acknowledge that reaches the limit leaves the pointer equal to the limit and clears enable.
- R11: `irq` equals complete AND (enable OR complete). It stays high until a clear-complete or reset command.
- R12: Read data appears on `bus_rdata` in the cycle after the read request and is zero in every other cycle. A bus write to an address register wins over a sequencer update of that register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_be | input | 4 | Byte enables; all must be set |
| bus_addr | input | 16 | Byte offset within the channel window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| dev_ack | input | 1 | Peripheral has moved one word |
| dev_req | output | 1 | Channel enabled and asking for transfers |
| mem_addr | output | 32 | Current memory pointer |
| xfer_dir | output | 1 | 1 = device to memory |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with its default parameters: 32-bit data, a 16-bit offset field and a step of 4 bytes. These values put every offset from the map within reach, including the 0x42xx pair. The reference model runs a chained buffer into its reload and then a single-update buffer into its stop. It also covers partial-enable and misaligned accesses, unmapped offsets, and a reset command combined with set-enable in the same write.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  localparam int NREG    = 6;
  localparam int AR_CUR  = 0;
  localparam int AR_LIM  = 1;
  localparam int AR_BEG  = 2;
  localparam int AR_END  = 3;
  localparam int AR_INIT = 4;
  localparam int AR_SIZE = 5;

  localparam logic [15:0] OFS_CSR = 16'h0000;

  // command bits (write) and flag bits (read) of the control register
  localparam int CB_SETEN = 0;
  localparam int CB_SETSU = 1;
  localparam int CB_DEV2M = 2;
  localparam int CB_CLRC  = 3;
  localparam int CB_RST   = 4;
  localparam int CMD_W    = 5;

  localparam int SB_EN  = 0;
  localparam int SB_SU  = 1;
  localparam int SB_DIR = 2;
  localparam int SB_CMP = 3;

  function automatic logic [15:0] areg_ofs(input int idx);
    case (idx)
      AR_CUR:  return 16'h4000;
      AR_LIM:  return 16'h4004;
      AR_BEG:  return 16'h4008;
      AR_END:  return 16'h400C;
      AR_INIT: return 16'h4200;
      default: return 16'h4204;
    endcase
  endfunction
endpackage

// File: rtl/dmach_dec.sv
module dmach_dec
  import dmach_pkg::*;
#(
  parameter int OFS_W = 16,
  parameter int BE_W  = 4
) (
  input  logic             sel,
  input  logic             wr,
  input  logic [BE_W-1:0]  be,
  input  logic [OFS_W-1:0] addr,
  output logic             rd_en,
  output logic             csr_hit,
  output logic             wr_csr,
  output logic [NREG-1:0]  areg_hit,
  output logic [NREG-1:0]  wr_areg
);
  logic acc_ok;

  assign acc_ok  = sel && (be == {BE_W{1'b1}}) && (addr[1:0] == 2'b00);
  assign rd_en   = acc_ok && !wr;
  assign csr_hit = acc_ok && (addr == OFS_W'(OFS_CSR));
  assign wr_csr  = csr_hit && wr;

  for (genvar g = 0; g < NREG; g++) begin : g_hit
    assign areg_hit[g] = acc_ok && (addr == OFS_W'(areg_ofs(g)));
    assign wr_areg[g]  = areg_hit[g] && wr;
  end
endmodule

// File: rtl/dmach_ctrl.sv
module dmach_ctrl
  import dmach_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_csr,
  input  logic [CMD_W-1:0] cmd,
  input  logic             done,
  output logic             en_q,
  output logic             su_q,
  output logic             dir_q,
  output logic             cmp_q
);
  logic en_n, su_n, dir_n, cmp_n;

  always_comb begin
    en_n  = en_q;
    su_n  = su_q;
    dir_n = dir_q;
    cmp_n = cmp_q;
    if (wr_csr) begin
      if (cmd[CB_SETEN]) en_n  = 1'b1;
      if (cmd[CB_SETSU]) su_n  = 1'b1;
      if (cmd[CB_DEV2M]) dir_n = 1'b1;
      if (cmd[CB_CLRC])  cmp_n = 1'b0;
    end
    if (done) begin
      cmp_n = 1'b1;
      if (su_q) en_n = 1'b0;
    end
    if (wr_csr && cmd[CB_RST]) begin
      en_n  = 1'b0;
      su_n  = 1'b0;
      dir_n = 1'b0;
      cmp_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      su_q  <= 1'b0;
      dir_q <= 1'b0;
      cmp_q <= 1'b0;
    end else begin
      en_q  <= en_n;
      su_q  <= su_n;
      dir_q <= dir_n;
      cmp_q <= cmp_n;
    end
  end

  // R5: reset command clears every flag
  p_reset_cmd_r5: assert property (@(posedge clk) disable iff (rst)
    wr_csr && cmd[CB_RST] |=> !en_q && !su_q && !dir_q && !cmp_q);

  // R6: an all-zero command leaves the flags alone
  p_zero_cmd_r6: assert property (@(posedge clk) disable iff (rst)
    wr_csr && (cmd == '0) && !done |=> $stable({en_q, su_q, dir_q, cmp_q}));

  // R9: reaching the limit sets complete
  p_done_sets_r9: assert property (@(posedge clk) disable iff (rst)
    done && !(wr_csr && cmd[CB_RST]) |=> cmp_q);

  // R10: single-update stops the channel at the limit
  p_single_stop_r10: assert property (@(posedge clk) disable iff (rst)
    done && su_q |=> !en_q);
endmodule

// File: rtl/dmach_addr.sv
module dmach_addr
  import dmach_pkg::*;
#(
  parameter int DW   = 32,
  parameter int STEP = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREG-1:0] wr_areg,
  input  logic [DW-1:0]   wdata,
  input  logic            ack,
  input  logic            en,
  input  logic            su,
  output logic [DW-1:0]   q [NREG],
  output logic            done
);
  logic [DW-1:0] nxt;
  logic          step_ok;
  logic [NREG-1:0] seq_upd;
  logic [DW-1:0]   seq_val [NREG];

  assign step_ok = en && ack;
  assign nxt     = q[AR_CUR] + DW'(STEP);
  assign done    = step_ok && (nxt == q[AR_LIM]);

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      seq_upd[i] = 1'b0;
      seq_val[i] = q[i];
    end
    if (step_ok) begin
      seq_upd[AR_CUR] = 1'b1;
      if (done && !su) begin
        seq_val[AR_CUR] = q[AR_BEG];
        seq_upd[AR_LIM] = 1'b1;
        seq_val[AR_LIM] = q[AR_END];
      end else begin
        seq_val[AR_CUR] = nxt;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst)             q[i] <= '0;
      else if (wr_areg[i]) q[i] <= wdata;
      else if (seq_upd[i]) q[i] <= seq_val[i];
    end
  end

  // R8: an accepted acknowledge moves the pointer by one step
  p_step_r8: assert property (@(posedge clk) disable iff (rst)
    step_ok && !done && !wr_areg[AR_CUR] |=> q[AR_CUR] == $past(q[AR_CUR]) + DW'(STEP));

  // R9: chained mode reloads the pointer from start
  p_reload_r9: assert property (@(posedge clk) disable iff (rst)
    done && !su && !wr_areg[AR_CUR] && !wr_areg[AR_BEG] |=> q[AR_CUR] == $past(q[AR_BEG]));
endmodule

// File: rtl/dmach_regs.sv
module dmach_regs
  import dmach_pkg::*;
#(
  parameter int DW    = 32,
  parameter int OFS_W = 16,
  parameter int STEP  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [DW/8-1:0]  bus_be,
  input  logic [OFS_W-1:0] bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic             dev_ack,
  output logic             dev_req,
  output logic [DW-1:0]    mem_addr,
  output logic             xfer_dir,
  output logic             irq
);
  localparam int BE_W = DW / 8;

  logic            rd_en, csr_hit, wr_csr, done;
  logic [NREG-1:0] areg_hit, wr_areg;
  logic            en_q, su_q, dir_q, cmp_q;
  logic [DW-1:0]   areg [NREG];
  logic [DW-1:0]   rd_val;

  dmach_dec #(.OFS_W(OFS_W), .BE_W(BE_W)) u_dec (
    .sel(bus_sel), .wr(bus_wr), .be(bus_be), .addr(bus_addr),
    .rd_en(rd_en), .csr_hit(csr_hit), .wr_csr(wr_csr),
    .areg_hit(areg_hit), .wr_areg(wr_areg)
  );

  dmach_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_csr(wr_csr), .cmd(bus_wdata[CMD_W-1:0]),
    .done(done), .en_q(en_q), .su_q(su_q), .dir_q(dir_q), .cmp_q(cmp_q)
  );

  dmach_addr #(.DW(DW), .STEP(STEP)) u_addr (
    .clk(clk), .rst(rst), .wr_areg(wr_areg), .wdata(bus_wdata),
    .ack(dev_ack), .en(en_q), .su(su_q), .q(areg), .done(done)
  );

  always_comb begin
    rd_val = '0;
    if (csr_hit) begin
      rd_val[SB_EN]  = en_q;
      rd_val[SB_SU]  = su_q;
      rd_val[SB_DIR] = dir_q;
      rd_val[SB_CMP] = cmp_q;
    end
    for (int i = 0; i < NREG; i++)
      if (areg_hit[i]) rd_val = rd_val | areg[i];
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_val;
    else            bus_rdata <= '0;
  end

  assign dev_req  = en_q;
  assign mem_addr = areg[AR_CUR];
  assign xfer_dir = dir_q;
  assign irq      = cmp_q & (en_q | cmp_q);

  // R11: interrupt holds until a clear-complete or reset command
  p_irq_hold_r11: assert property (@(posedge clk) disable iff (rst)
    irq && !(wr_csr && (bus_wdata[CB_CLRC] || bus_wdata[CB_RST])) |=> irq);

  // R1: a read with partial byte enables returns zero
  p_partial_read_r1: assert property (@(posedge clk) disable iff (rst)
    bus_sel && !bus_wr && (bus_be != {BE_W{1'b1}}) |=> bus_rdata == '0);

  // R8: with no request and no pointer write the address is stable
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !dev_req && !wr_areg[AR_CUR] |=> $stable(mem_addr));
endmodule

// File: tb/tb_dmach_regs.sv
module tb_dmach_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_be = 4'h0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dev_ack = 1'b0;
  logic        dev_req, xfer_dir, irq;
  logic [31:0] mem_addr;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit started = 0;

  always #2 clk = ~clk;

  dmach_regs dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_be(bus_be),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dev_ack(dev_ack), .dev_req(dev_req), .mem_addr(mem_addr),
    .xfer_dir(xfer_dir), .irq(irq)
  );

  // behavioural reference model
  bit [31:0] m_cur, m_lim, m_beg, m_end, m_init, m_size, m_rd, v;
  bit m_en, m_su, m_dir, m_cmp, ok, hit;

  function automatic bit [31:0] m_lookup(input bit [15:0] a);
    case (a)
      16'h0000: return {28'd0, m_cmp, m_dir, m_su, m_en};
      16'h4000: return m_cur;
      16'h4004: return m_lim;
      16'h4008: return m_beg;
      16'h400C: return m_end;
      16'h4200: return m_init;
      16'h4204: return m_size;
      default:  return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      {m_cur, m_lim, m_beg, m_end, m_init, m_size, m_rd} = '0;
      {m_en, m_su, m_dir, m_cmp} = '0;
    end else begin
      ok  = bus_sel && bus_be == 4'hF && bus_addr[1:0] == 2'b00;
      hit = m_en && dev_ack && (m_cur + 32'd4 == m_lim);
      m_rd = (ok && !bus_wr) ? m_lookup(bus_addr) : 32'd0;
      v = m_cur;
      if (m_en && dev_ack) begin
        if (hit && !m_su) begin m_cur = m_beg; m_lim = m_end; end
        else m_cur = v + 32'd4;
      end
      if (ok && bus_wr) begin
        case (bus_addr)
          16'h4000: m_cur  = bus_wdata;
          16'h4004: m_lim  = bus_wdata;
          16'h4008: m_beg  = bus_wdata;
          16'h400C: m_end  = bus_wdata;
          16'h4200: m_init = bus_wdata;
          16'h4204: m_size = bus_wdata;
          default: ;
        endcase
      end
      if (hit) begin
        if (m_su) m_en = 1'b0;
      end
      if (ok && bus_wr && bus_addr == 16'h0000) begin
        if (bus_wdata[0]) m_en = 1'b1;
        if (bus_wdata[1]) m_su = 1'b1;
        if (bus_wdata[2]) m_dir = 1'b1;
        if (bus_wdata[3]) m_cmp = 1'b0;
      end
      if (hit) m_cmp = 1'b1;
      if (ok && bus_wr && bus_addr == 16'h0000 && bus_wdata[4])
        {m_en, m_su, m_dir, m_cmp} = '0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare against the model on every cycle, away from the clock edge
  always @(negedge clk) begin
    if (started && !rst) begin
      chk("R8 mem_addr", mem_addr, m_cur);
      chk("R8 dev_req", {31'd0, dev_req}, {31'd0, m_en});
      chk("R3 xfer_dir", {31'd0, xfer_dir}, {31'd0, m_dir});
      chk("R11 irq", {31'd0, irq}, {31'd0, m_cmp & (m_en | m_cmp)});
      chk("R12 rdata", bus_rdata, m_rd);
    end
  end

  task automatic wr(input [15:0] a, input [31:0] d, input [3:0] be = 4'hF);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_be = 0;
  endtask

  task automatic rd(input [15:0] a, input [31:0] exp, input string tag, input [3:0] be = 4'hF);
    bus_sel = 1; bus_wr = 0; bus_addr = a; bus_be = be;
    @(negedge clk);
    bus_sel = 0; bus_be = 0;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic acks(input int n);
    dev_ack = 1;
    repeat (n) @(negedge clk);
    dev_ack = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    started = 1;
    @(negedge clk);
    chk("R11 reset irq", {31'd0, irq}, 32'd0);
    rd(16'h0000, 32'h0, "R3 reset csr");
    // R2 address registers
    wr(16'h4000, 32'h0000_1000);
    wr(16'h4004, 32'h0000_1010);
    wr(16'h4008, 32'h0000_2000);
    wr(16'h400C, 32'h0000_2008);
    wr(16'h4200, 32'hAAAA_5555);
    wr(16'h4204, 32'h0000_0040);
    rd(16'h4000, 32'h0000_1000, "R2 cur");
    rd(16'h4004, 32'h0000_1010, "R2 lim");
    rd(16'h4008, 32'h0000_2000, "R2 start");
    rd(16'h400C, 32'h0000_2008, "R2 stop");
    rd(16'h4200, 32'hAAAA_5555, "R2 init");
    rd(16'h4204, 32'h0000_0040, "R2 size");
    // R1 word-only
    wr(16'h4204, 32'h1234_5678, 4'h3);
    wr(16'h4206, 32'h1234_5678);
    rd(16'h4204, 32'h0000_0040, "R1 size unchanged");
    rd(16'h4204, 32'h0, "R1 partial read", 4'h1);
    // R7 unmapped
    wr(16'h4100, 32'hFFFF_FFFF);
    rd(16'h4100, 32'h0, "R7 unmapped");
    rd(16'h0004, 32'h0, "R7 unmapped low");
    // R3 / R6 commands
    wr(16'h0000, 32'h4);
    rd(16'h0000, 32'h4, "R3 dir set");
    wr(16'h0000, 32'h1);
    rd(16'h0000, 32'h5, "R3 enable set");
    chk("R8 dev_req on", {31'd0, dev_req}, 32'd1);
    wr(16'h0000, 32'h0);
    rd(16'h0000, 32'h5, "R6 zero write");
    // R8 / R9 chained buffer
    acks(3);
    chk("R8 three steps", mem_addr, 32'h0000_100C);
    acks(1);
    chk("R9 reload cur", mem_addr, 32'h0000_2000);
    chk("R9 irq", {31'd0, irq}, 32'd1);
    rd(16'h0000, 32'hD, "R9 csr after wrap");
    rd(16'h4004, 32'h0000_2008, "R9 limit reloaded");
    repeat (4) @(negedge clk);
    chk("R11 irq held", {31'd0, irq}, 32'd1);
    wr(16'h0000, 32'h8);
    chk("R4 clear complete irq", {31'd0, irq}, 32'd0);
    // R10 single update
    wr(16'h0000, 32'h2);
    rd(16'h0000, 32'h7, "R4 single set");
    acks(2);
    chk("R10 stop at limit", mem_addr, 32'h0000_2008);
    rd(16'h0000, 32'hE, "R10 csr stopped");
    acks(2);
    chk("R8 ack ignored when off", mem_addr, 32'h0000_2008);
    // R5 reset beats set-enable
    wr(16'h0000, 32'h11);
    rd(16'h0000, 32'h0, "R5 reset command");
    chk("R5 irq low", {31'd0, irq}, 32'd0);
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule